// File: doc/BRIEF.md
# Virtual Interrupt Acknowledge and Completion Unit

This unit serves one virtual processor. It holds a small set of list entries, each carrying a virtual interrupt ID, a priority, a group bit and a two-bit state. The guest reads an acknowledge register to take the best pending interrupt, and a highest-pending register to look at it without taking it. It writes an end-of-interrupt register, or its alias, to finish an interrupt. A separate deactivate register is used when the split completion mode is selected. A stack of active priorities tracks preemption: an acknowledge succeeds only when the candidate is strictly more urgent than the running priority, and a priority drop pops that stack.

When an interrupt is deactivated, its list entry is updated and a one-cycle completion pulse carrying the ID goes toward the distributor. A control register at offset 0x000 selects two behaviours. The first is whether end-of-interrupt also deactivates. The second is whether group 1 interrupts are hidden behind the spurious ID 1022. The hypervisor fills list entries through a load port that writes one entry per cycle.

Top module: `vint_ack_unit`

## Requirements
- R1: The control register at offset 0x000 resets to zero. Only bits 9 (completion mode), 4, 3, 2 (group 1 acknowledge enable), 1 and 0 store written values. Every other bit reads as zero whatever was written.
- R2: A read at offset 0x008 returns the highest-pending ID and changes no state. The candidate is the entry in state pending (2'b01) with the numerically lowest priority, and a tie goes to the lowest entry index. The read returns 1023 when no entry is pending.
- R3: A read at offset 0x004 returns the candidate's ID, moves that entry to active (2'b10) and pushes its priority on the active stack. When the stack is not empty and the candidate priority is not strictly below the stack top, the read returns 1023 and changes nothing.
- R4: With control bit 2 at 0 and a group 1 candidate (group bit 1), reads at 0x004 and 0x008 return 1022 and nothing is acknowledged. With bit 2 at 1, the real ID is returned.
- R5: With control bit 9 at 0, a write to 0x010 or to its alias 0x014 pops the stack and deactivates the entry whose ID equals write data bits [9:0]. A write with an empty stack is ignored entirely.
- R6: With control bit 9 at 1, a write to 0x010 or 0x014 only pops the stack. No entry changes and no completion is raised.
- R7: With control bit 9 at 1, a write to 0x020 deactivates the lowest-index entry whose ID matches and whose state is active or pending+active (2'b11). Active becomes invalid (2'b00) and pending+active becomes pending. cmpl_valid pulses for one cycle with the ID on cmpl_id. A write with no match raises nothing.
- R8: With control bit 9 at 0, a write to 0x020 changes no entry and raises no completion. It pulses bad_deact for one cycle.
- R9: ld_valid writes the whole entry at ld_idx. A bus access in the same cycle sees the entry's previous contents, and the loaded value is what remains afterwards.
- R10: Read data and bus_rvalid appear in the cycle after a read request. Writes raise no bus_rvalid, and reads of unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Register access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read |
| ld_valid | input | 1 | Load one list entry |
| ld_idx | input | IDX_W | Entry index to load |
| ld_id | input | VID_W | Interrupt ID to load |
| ld_prio | input | VPRIO_W | Priority to load |
| ld_grp | input | 1 | Group bit to load |
| ld_state | input | 2 | State to load: 00 invalid, 01 pending, 10 active, 11 pending+active |
| cmpl_valid | output | 1 | Completion pulse toward the distributor |
| cmpl_id | output | VID_W | ID of the completed interrupt |
| bad_deact | output | 1 | Pulse on a deactivate write made in combined mode |

## Verification
An acknowledge read and a hypervisor load of the same list entry can fall in one cycle. The bench provokes this by driving ld_valid together with a read at 0x004 that targets the pending entry. It judges the result three ways. The read must return the old ID. A following highest-pending read must show the newly loaded ID. A completion written for the old ID must find no matching entry, while the new entry can be acknowledged and completed normally.

// File: rtl/vint_pkg.sv
package vint_pkg;

    parameter int unsigned VID_W   = 10;
    parameter int unsigned VPRIO_W = 5;

    typedef enum logic [1:0] {
        ST_INVALID  = 2'b00,
        ST_PENDING  = 2'b01,
        ST_ACTIVE   = 2'b10,
        ST_PEND_ACT = 2'b11
    } vstate_e;

    typedef struct packed {
        logic [VID_W-1:0]   id;
        logic [VPRIO_W-1:0] prio;
        logic               grp;
        vstate_e            st;
    } lr_entry_t;

    localparam int unsigned OFF_CTRL  = 'h000;
    localparam int unsigned OFF_ACK   = 'h004;
    localparam int unsigned OFF_HPEND = 'h008;
    localparam int unsigned OFF_EOI   = 'h010;
    localparam int unsigned OFF_AEOI  = 'h014;
    localparam int unsigned OFF_DEACT = 'h020;

    localparam logic [31:0] CTRL_WMASK = 32'h0000_021F;
    localparam int unsigned CB_MODE    = 9;
    localparam int unsigned CB_G1ACK   = 2;

    localparam logic [31:0] ID_SPUR_G1 = 32'd1022;
    localparam logic [31:0] ID_NONE    = 32'd1023;

    function automatic logic [31:0] id_word(input logic [VID_W-1:0] id);
        return {{(32-VID_W){1'b0}}, id};
    endfunction

endpackage

// File: rtl/vint_select.sv
module vint_select
    import vint_pkg::*;
#(
    parameter int unsigned N_LR  = 4,
    localparam int unsigned IDX_W = (N_LR > 1) ? $clog2(N_LR) : 1
) (
    input  lr_entry_t        ent [N_LR],
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    logic [VPRIO_W-1:0] bestp;

    always_comb begin
        found = 1'b0;
        idx   = '0;
        bestp = '0;
        for (int i = 0; i < N_LR; i++) begin
            if (ent[i].st == ST_PENDING && (!found || ent[i].prio < bestp)) begin
                found = 1'b1;
                idx   = IDX_W'(i);
                bestp = ent[i].prio;
            end
        end
    end
endmodule

// File: rtl/vint_prio_stack.sv
module vint_prio_stack #(
    parameter int unsigned DEPTH = 4,
    parameter int unsigned W     = 5,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1),
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] push_prio,
    output logic [W-1:0] top,
    output logic         empty,
    output logic         full
);
    logic [W-1:0]     mem [DEPTH];
    logic [CNT_W-1:0] cnt;

    assign empty = (cnt == '0);
    assign full  = (cnt == CNT_W'(DEPTH));
    assign top   = empty ? '0 : mem[PTR_W'(cnt - 1'b1)];

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (push && !full) begin
            mem[PTR_W'(cnt)] <= push_prio;
            cnt              <= cnt + 1'b1;
        end else if (pop && !empty) begin
            cnt <= cnt - 1'b1;
        end
    end

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst) push |-> !full);
    a_r5_no_underflow: assert property (@(posedge clk) disable iff (rst) pop |-> !empty);
    a_r3_push_pop_excl: assert property (@(posedge clk) disable iff (rst) !(push && pop));
endmodule

// File: rtl/vint_ack_unit.sv
module vint_ack_unit
    import vint_pkg::*;
#(
    parameter int unsigned N_LR      = 4,
    parameter int unsigned STK_DEPTH = 4,
    parameter int unsigned ADDR_W    = 12,
    localparam int unsigned IDX_W    = (N_LR > 1) ? $clog2(N_LR) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_req,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic               bus_rvalid,
    input  logic               ld_valid,
    input  logic [IDX_W-1:0]   ld_idx,
    input  logic [VID_W-1:0]   ld_id,
    input  logic [VPRIO_W-1:0] ld_prio,
    input  logic               ld_grp,
    input  logic [1:0]         ld_state,
    output logic               cmpl_valid,
    output logic [VID_W-1:0]   cmpl_id,
    output logic               bad_deact
);
    lr_entry_t          lr [N_LR];
    logic [31:0]        ctrl_q;
    logic               sel_found;
    logic [IDX_W-1:0]   sel_idx;
    logic [VPRIO_W-1:0] stk_top;
    logic               stk_empty, stk_full;
    logic               m_found;
    logic [IDX_W-1:0]   m_idx;
    lr_entry_t          best;

    logic rd, wr, a_ctrl, a_ack, a_hpend, a_eoi, a_deact;
    logic mode_split, g1_ack_en, g1_masked, preempt_ok;
    logic ack_grant, drop, deact_req, deact_hit, bad_now;
    logic [31:0] ack_val, hpend_val, rd_val;
    logic [VID_W-1:0] wid;

    assign rd      = bus_req && !bus_we;
    assign wr      = bus_req && bus_we;
    assign a_ctrl  = (bus_addr == ADDR_W'(OFF_CTRL));
    assign a_ack   = (bus_addr == ADDR_W'(OFF_ACK));
    assign a_hpend = (bus_addr == ADDR_W'(OFF_HPEND));
    assign a_eoi   = (bus_addr == ADDR_W'(OFF_EOI)) || (bus_addr == ADDR_W'(OFF_AEOI));
    assign a_deact = (bus_addr == ADDR_W'(OFF_DEACT));
    assign wid     = bus_wdata[VID_W-1:0];

    assign mode_split = ctrl_q[CB_MODE];
    assign g1_ack_en  = ctrl_q[CB_G1ACK];

    vint_select #(.N_LR(N_LR)) u_sel (
        .ent   (lr),
        .found (sel_found),
        .idx   (sel_idx)
    );

    assign best       = lr[sel_idx];
    assign g1_masked  = sel_found && best.grp && !g1_ack_en;
    assign preempt_ok = stk_empty || (best.prio < stk_top);
    assign ack_grant  = rd && a_ack && sel_found && !g1_masked && preempt_ok && !stk_full;

    always_comb begin
        if (!sel_found)                  ack_val = ID_NONE;
        else if (g1_masked)              ack_val = ID_SPUR_G1;
        else if (!preempt_ok || stk_full) ack_val = ID_NONE;
        else                             ack_val = id_word(best.id);
        if (!sel_found)                  hpend_val = ID_NONE;
        else if (g1_masked)              hpend_val = ID_SPUR_G1;
        else                             hpend_val = id_word(best.id);
        if (a_ctrl)                      rd_val = ctrl_q;
        else if (a_ack)                  rd_val = ack_val;
        else if (a_hpend)                rd_val = hpend_val;
        else                             rd_val = '0;
    end

    assign drop      = wr && a_eoi && !stk_empty;
    assign deact_req = (drop && !mode_split) || (wr && a_deact && mode_split);
    assign bad_now   = wr && a_deact && !mode_split;

    always_comb begin
        m_found = 1'b0;
        m_idx   = '0;
        for (int i = N_LR - 1; i >= 0; i--) begin
            if (lr[i].id == wid && lr[i].st[1]) begin
                m_found = 1'b1;
                m_idx   = IDX_W'(i);
            end
        end
    end
    assign deact_hit = deact_req && m_found;

    vint_prio_stack #(.DEPTH(STK_DEPTH), .W(VPRIO_W)) u_stk (
        .clk       (clk),
        .rst       (rst),
        .push      (ack_grant),
        .pop       (drop),
        .push_prio (best.prio),
        .top       (stk_top),
        .empty     (stk_empty),
        .full      (stk_full)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_LR; i++) lr[i] <= '0;
        end else begin
            if (ack_grant) lr[sel_idx].st <= ST_ACTIVE;
            if (deact_hit)
                lr[m_idx].st <= (lr[m_idx].st == ST_PEND_ACT) ? ST_PENDING : ST_INVALID;
            if (ld_valid)
                lr[ld_idx] <= '{id: ld_id, prio: ld_prio, grp: ld_grp, st: vstate_e'(ld_state)};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q     <= '0;
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
            cmpl_valid <= 1'b0;
            cmpl_id    <= '0;
            bad_deact  <= 1'b0;
        end else begin
            if (wr && a_ctrl) ctrl_q <= bus_wdata & CTRL_WMASK;
            bus_rvalid <= rd;
            bus_rdata  <= rd ? rd_val : '0;
            cmpl_valid <= deact_hit;
            cmpl_id    <= deact_hit ? lr[m_idx].id : '0;
            bad_deact  <= bad_now;
        end
    end

    a_r10_rvalid_after_read: assert property (@(posedge clk) disable iff (rst)
        bus_rvalid |-> $past(rd));
    a_r7_cmpl_cause: assert property (@(posedge clk) disable iff (rst)
        cmpl_valid |-> $past(wr && ((a_deact && mode_split) || (a_eoi && !mode_split))));
    a_r8_bad_no_cmpl: assert property (@(posedge clk) disable iff (rst)
        bad_deact |-> !cmpl_valid);
    a_r1_ctrl_res0: assert property (@(posedge clk) disable iff (rst)
        (bus_rvalid && $past(a_ctrl)) |-> ((bus_rdata & ~CTRL_WMASK) == 32'd0));
    a_r6_no_cmpl_on_split_eoi: assert property (@(posedge clk) disable iff (rst)
        (wr && a_eoi && mode_split) |=> !cmpl_valid);
endmodule

// File: tb/tb_vint_ack_unit.sv
`timescale 1ns/1ps
module tb_vint_ack_unit;
    import vint_pkg::*;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_req, bus_we;
    logic [11:0] bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic        bus_rvalid;
    logic        ld_valid;
    logic [1:0]  ld_idx;
    logic [9:0]  ld_id;
    logic [4:0]  ld_prio;
    logic        ld_grp;
    logic [1:0]  ld_state;
    logic        cmpl_valid;
    logic [9:0]  cmpl_id;
    logic        bad_deact;

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] r_data;
    logic        r_valid, r_cmpl, r_bad;
    logic [9:0]  r_cid;

    vint_ack_unit dut (
        .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
        .ld_valid(ld_valid), .ld_idx(ld_idx), .ld_id(ld_id), .ld_prio(ld_prio),
        .ld_grp(ld_grp), .ld_state(ld_state), .cmpl_valid(cmpl_valid),
        .cmpl_id(cmpl_id), .bad_deact(bad_deact)
    );

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_op();
        @(negedge clk);
        r_data  = bus_rdata;
        r_valid = bus_rvalid;
        r_cmpl  = cmpl_valid;
        r_cid   = cmpl_id;
        r_bad   = bad_deact;
        bus_req  = 1'b0;
        bus_we   = 1'b0;
        ld_valid = 1'b0;
    endtask

    task automatic bwr(input int addr, input int data);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = 12'(addr); bus_wdata = 32'(data);
        finish_op();
    endtask

    task automatic brd(input int addr);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = 12'(addr);
        finish_op();
    endtask

    task automatic set_ld(input int idx, input int id, input int prio, input bit grp, input int st);
        ld_valid = 1'b1; ld_idx = 2'(idx); ld_id = 10'(id);
        ld_prio = 5'(prio); ld_grp = grp; ld_state = 2'(st);
    endtask

    task automatic load(input int idx, input int id, input int prio, input bit grp, input int st);
        @(negedge clk);
        set_ld(idx, id, prio, grp, st);
        finish_op();
    endtask

    task automatic expect_read(input int addr, input int exp, input string req);
        brd(addr);
        chk(r_valid && r_data == 32'(exp), req, $sformatf("read 0x%0h", addr), int'(r_data), exp);
    endtask

    task automatic expect_wr(input int addr, input int data, input bit exp_c, input int exp_id,
                             input string req);
        bwr(addr, data);
        chk(r_cmpl == exp_c, req, $sformatf("cmpl_valid after write 0x%0h", addr), r_cmpl, exp_c);
        if (exp_c) chk(r_cid == 10'(exp_id), req, "cmpl_id", r_cid, exp_id);
        chk(!r_valid, "R10", "rvalid after write", r_valid, 0);
    endtask

    task automatic t_reset();
        expect_read('h000, 0, "R1");
        expect_read('h008, 1023, "R2");
        expect_read('h004, 1023, "R3");
    endtask

    task automatic t_ctrl();
        bwr('h000, 32'hFFFF_FFFF);
        expect_read('h000, 'h21F, "R1");
        bwr('h000, 32'h0);
        expect_read('h000, 0, "R1");
        expect_read('h030, 0, "R10");
    endtask

    task automatic t_select_mode0();
        load(0, 40, 8, 0, 1);
        load(1, 41, 3, 0, 1);
        load(2, 42, 3, 0, 1);
        load(3, 43, 0, 0, 0);
        expect_read('h008, 41, "R2");
        expect_read('h008, 41, "R2");
        expect_read('h004, 41, "R3");
        expect_read('h008, 42, "R2");
        expect_read('h004, 1023, "R3");
        expect_wr('h010, 41, 1, 41, "R5");
        expect_read('h004, 42, "R3");
        expect_wr('h014, 42, 1, 42, "R5");
        expect_wr('h010, 40, 0, 0, "R5");
        expect_read('h008, 40, "R5");
        expect_read('h004, 40, "R3");
        expect_wr('h010, 40, 1, 40, "R5");
        expect_read('h008, 1023, "R2");
    endtask

    task automatic t_group1();
        load(0, 100, 2, 1, 1);
        load(1, 101, 6, 0, 1);
        expect_read('h008, 1022, "R4");
        expect_read('h004, 1022, "R4");
        expect_read('h008, 1022, "R4");
        bwr('h000, 'h004);
        expect_read('h008, 100, "R4");
        expect_read('h004, 100, "R4");
        expect_wr('h010, 100, 1, 100, "R4");
        expect_read('h004, 101, "R3");
        expect_wr('h010, 101, 1, 101, "R5");
    endtask

    task automatic t_split();
        bwr('h000, 'h204);
        load(2, 200, 10, 0, 1);
        expect_read('h004, 200, "R3");
        load(3, 201, 4, 0, 1);
        expect_read('h004, 201, "R3");
        load(1, 202, 7, 0, 1);
        expect_read('h004, 1023, "R6");
        expect_wr('h010, 201, 0, 0, "R6");
        expect_read('h004, 202, "R6");
        expect_wr('h020, 201, 1, 201, "R7");
        expect_wr('h020, 201, 0, 0, "R7");
        expect_wr('h014, 202, 0, 0, "R6");
        expect_wr('h010, 200, 0, 0, "R6");
        expect_wr('h020, 202, 1, 202, "R7");
        expect_wr('h020, 200, 1, 200, "R7");
        load(0, 210, 9, 0, 3);
        expect_read('h008, 1023, "R7");
        expect_wr('h020, 210, 1, 210, "R7");
        expect_read('h008, 210, "R7");
        expect_read('h004, 210, "R7");
        expect_wr('h010, 210, 0, 0, "R6");
        expect_wr('h020, 210, 1, 210, "R7");
    endtask

    task automatic t_bad_deact();
        bwr('h000, 'h004);
        load(0, 220, 1, 0, 1);
        expect_read('h004, 220, "R8");
        bwr('h020, 220);
        chk(r_bad == 1'b1, "R8", "bad_deact", r_bad, 1);
        chk(r_cmpl == 1'b0, "R8", "cmpl_valid", r_cmpl, 0);
        @(negedge clk);
        chk(bad_deact == 1'b0, "R8", "bad_deact single cycle", bad_deact, 0);
        expect_wr('h010, 220, 1, 220, "R8");
    endtask

    task automatic t_collide();
        load(1, 230, 5, 0, 1);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = 12'h004;
        set_ld(1, 231, 6, 0, 1);
        finish_op();
        chk(r_valid && r_data == 32'd230, "R9", "ack with load", int'(r_data), 230);
        expect_read('h008, 231, "R9");
        expect_wr('h010, 230, 0, 0, "R9");
        expect_read('h004, 231, "R9");
        expect_wr('h010, 231, 1, 231, "R9");
    endtask

    initial begin
        #(8 * 200000);
        chk(1'b0, "WDOG", "watchdog expired", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; bus_req = 0; bus_we = 0; bus_addr = 0; bus_wdata = 0;
        ld_valid = 0; ld_idx = 0; ld_id = 0; ld_prio = 0; ld_grp = 0; ld_state = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_ctrl();
        t_select_mode0();
        t_group1();
        t_split();
        t_bad_deact();
        t_collide();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule